// File: doc/BRIEF.md
# Call and Return Frame Sequencer

This block performs the memory side of subroutine linkage for a small processor core. When the core's decoder asks for a call or a return, the block walks a short, fixed sequence of 32-bit stack accesses through one request/ready memory port. It keeps working copies of the frame pointer (register 0) and stack pointer (register 1) while it runs. When the sequence ends it presents the updated frame pointer, stack pointer and the next program counter for one cycle, marked by a done pulse.

Three operations exist: a call to an absolute target taken from the instruction immediate, a call to a target held in a general register, and a return. Every frame holds three words: the saved frame pointer at the lowest address, the return address four bytes above it, and one unused static-chain word above that. A call therefore lowers the stack pointer twice, by 8 and then by 4. A return rebuilds the stack pointer from the frame pointer and climbs back over all three words. The decoder stays responsible for register selection and for all other register writeback.

Top module: `frame_seq`

## Requirements
- R1: After reset, busy, done and the memory request are all low, and the pc, frame pointer and stack pointer outputs read zero.
- R2: An absolute call (op code 0) stores pc+6 at sp-8 and then the old frame pointer at sp-12. At done it outputs fp = sp = old sp-12 and pc = the immediate.
- R3: A register call (op code 1) does the same two stores, except that the stored return address is pc+2 and the target is the register value input.
- R4: A return (op code 2) first reads the word at the incoming frame pointer, which becomes the new frame pointer. It then reads the word at frame pointer+4, which becomes the new pc. At done the stack pointer is the incoming frame pointer+12.
- R5: A memory request is raised only while busy. It keeps its address, write enable and write data unchanged until the cycle in which ready is high.
- R6: Done is high for exactly one cycle per sequence, and busy is low in that cycle. Busy is high in every cycle from the one after an accepted start until done.
- R7: A start that arrives while busy is ignored: it causes no extra memory access and does not change the result of the running sequence.
- R8: Op code 3 is not accepted: busy stays low and no memory request is made.
- R9: Stack addresses wrap modulo 2^32, so a call with sp = 4 stores at 0xFFFFFFFC and 0xFFFFFFF8, and the matching return brings sp back to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to begin a sequence |
| op_i | input | 2 | 0 absolute call, 1 register call, 2 return, 3 unused |
| pc_i | input | 32 | Address of the call or return instruction |
| imm_i | input | 32 | Immediate target for an absolute call |
| reg_val_i | input | 32 | Selected register value for a register call |
| fp_i | input | 32 | Current frame pointer (register 0) |
| sp_i | input | 32 | Current stack pointer (register 1) |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pc_o | output | 32 | Next program counter, valid with done |
| fp_o | output | 32 | Updated frame pointer, valid with done |
| sp_o | output | 32 | Updated stack pointer, valid with done |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 for a store, 0 for a load |
| mem_addr_o | output | 32 | Byte address of the access |
| mem_wdata_o | output | 32 | Store data |
| mem_rdata_i | input | 32 | Load data, valid with ready |
| mem_ready_i | input | 1 | Memory accepts or completes the access |

## Verification
A corrupted working stack pointer shows up on the memory address port at the very next access. This is normally the second store of a call or the second load of a return, one handshake after the fault, and it shows again in sp_o at done. A wrong sequencer state shows up as an extra, missing or reordered transfer, which the transfer scoreboard catches at the handshake where it happens. A lost or doubled done is caught within one cycle. A frame pointer fault only shows up at done, or at the saved-frame-pointer store of a call.

// File: rtl/frame_seq_pkg.sv
package frame_seq_pkg;
   typedef enum logic [1:0] {
      OP_CALL_IMM = 2'd0,
      OP_CALL_REG = 2'd1,
      OP_RETURN   = 2'd2,
      OP_UNUSED   = 2'd3
   } fs_op_e;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_PUSH_LINK = 3'd1,
      ST_PUSH_FRAME = 3'd2,
      ST_POP_FRAME  = 3'd3,
      ST_POP_LINK   = 3'd4
   } fs_state_e;
endpackage

// File: rtl/frame_seq_ctrl.sv
module frame_seq_ctrl
   import frame_seq_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start_i,
   input  logic [1:0] op_i,
   input  logic      mem_ready_i,
   output fs_state_e state_o,
   output logic      accept_o,
   output logic      step_o,
   output logic      done_o
);
   fs_state_e state_q, state_d;
   logic      done_q;

   assign accept_o = start_i && (state_q == ST_IDLE) && (op_i != OP_UNUSED);
   assign step_o   = (state_q != ST_IDLE) && mem_ready_i;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:       if (accept_o) state_d = (op_i == OP_RETURN) ? ST_POP_FRAME : ST_PUSH_LINK;
         ST_PUSH_LINK:  if (step_o) state_d = ST_PUSH_FRAME;
         ST_PUSH_FRAME: if (step_o) state_d = ST_IDLE;
         ST_POP_FRAME:  if (step_o) state_d = ST_POP_LINK;
         ST_POP_LINK:   if (step_o) state_d = ST_IDLE;
         default:       state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= step_o && ((state_q == ST_PUSH_FRAME) || (state_q == ST_POP_LINK));
      end
   end

   assign state_o = state_q;
   assign done_o  = done_q;
endmodule

// File: rtl/frame_seq_datapath.sv
module frame_seq_datapath
   import frame_seq_pkg::*;
#(
   parameter int DW          = 32,
   parameter int SLOT_BYTES  = 4,
   parameter int CHAIN_SLOTS = 1,
   parameter int LEN_LONG    = 6,
   parameter int LEN_SHORT   = 2,
   parameter bit ALIGN_ADDR  = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  fs_state_e     state_i,
   input  logic          accept_i,
   input  logic          step_i,
   input  logic [1:0]    op_i,
   input  logic [DW-1:0] pc_i,
   input  logic [DW-1:0] imm_i,
   input  logic [DW-1:0] reg_val_i,
   input  logic [DW-1:0] fp_i,
   input  logic [DW-1:0] sp_i,
   input  logic [DW-1:0] mem_rdata_i,
   output logic          mem_we_o,
   output logic [DW-1:0] mem_addr_o,
   output logic [DW-1:0] mem_wdata_o,
   output logic [DW-1:0] pc_o,
   output logic [DW-1:0] fp_o,
   output logic [DW-1:0] sp_o
);
   localparam int LINK_DROP  = SLOT_BYTES * (1 + CHAIN_SLOTS);
   localparam int FRAME_STEP = SLOT_BYTES;
   localparam logic [DW-1:0] LINK_DROP_V  = DW'(LINK_DROP);
   localparam logic [DW-1:0] FRAME_STEP_V = DW'(FRAME_STEP);
   localparam logic [DW-1:0] ALIGN_MASK   = ~(DW'(SLOT_BYTES) - DW'(1));

   logic [DW-1:0] fp_q, sp_q, pc_q, link_q, dest_q;
   logic [DW-1:0] raw_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fp_q   <= '0;
         sp_q   <= '0;
         pc_q   <= '0;
         link_q <= '0;
         dest_q <= '0;
      end else if (accept_i) begin
         fp_q   <= fp_i;
         sp_q   <= (op_i == OP_RETURN) ? fp_i : sp_i;
         link_q <= pc_i + ((op_i == OP_CALL_IMM) ? DW'(LEN_LONG) : DW'(LEN_SHORT));
         dest_q <= (op_i == OP_CALL_IMM) ? imm_i : reg_val_i;
      end else if (step_i) begin
         case (state_i)
            ST_PUSH_LINK: sp_q <= sp_q - LINK_DROP_V;
            ST_PUSH_FRAME: begin
               sp_q <= sp_q - FRAME_STEP_V;
               fp_q <= sp_q - FRAME_STEP_V;
               pc_q <= dest_q;
            end
            ST_POP_FRAME: begin
               fp_q <= mem_rdata_i;
               sp_q <= sp_q + FRAME_STEP_V;
            end
            ST_POP_LINK: begin
               pc_q <= mem_rdata_i;
               sp_q <= sp_q + LINK_DROP_V;
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      raw_addr    = sp_q;
      mem_wdata_o = '0;
      mem_we_o    = 1'b0;
      case (state_i)
         ST_PUSH_LINK: begin
            raw_addr    = sp_q - LINK_DROP_V;
            mem_wdata_o = link_q;
            mem_we_o    = 1'b1;
         end
         ST_PUSH_FRAME: begin
            raw_addr    = sp_q - FRAME_STEP_V;
            mem_wdata_o = fp_q;
            mem_we_o    = 1'b1;
         end
         default: raw_addr = sp_q;
      endcase
   end

   generate
      if (ALIGN_ADDR) begin : g_align
         assign mem_addr_o = raw_addr & ALIGN_MASK;
      end else begin : g_raw
         assign mem_addr_o = raw_addr;
      end
   endgenerate

   assign pc_o = pc_q;
   assign fp_o = fp_q;
   assign sp_o = sp_q;
endmodule

// File: rtl/frame_seq.sv
module frame_seq
   import frame_seq_pkg::*;
#(
   parameter int DW          = 32,
   parameter int SLOT_BYTES  = 4,
   parameter int CHAIN_SLOTS = 1,
   parameter int LEN_LONG    = 6,
   parameter int LEN_SHORT   = 2,
   parameter bit ALIGN_ADDR  = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [1:0]    op_i,
   input  logic [DW-1:0] pc_i,
   input  logic [DW-1:0] imm_i,
   input  logic [DW-1:0] reg_val_i,
   input  logic [DW-1:0] fp_i,
   input  logic [DW-1:0] sp_i,
   output logic          busy_o,
   output logic          done_o,
   output logic [DW-1:0] pc_o,
   output logic [DW-1:0] fp_o,
   output logic [DW-1:0] sp_o,
   output logic          mem_req_o,
   output logic          mem_we_o,
   output logic [DW-1:0] mem_addr_o,
   output logic [DW-1:0] mem_wdata_o,
   input  logic [DW-1:0] mem_rdata_i,
   input  logic          mem_ready_i
);
   generate
      if (DW < 16) begin : g_bad_width
         $error("frame_seq: DW must be at least 16");
      end
      if ((SLOT_BYTES < 1) || ((SLOT_BYTES & (SLOT_BYTES - 1)) != 0)) begin : g_bad_slot
         $error("frame_seq: SLOT_BYTES must be a power of two");
      end
      if (CHAIN_SLOTS < 0) begin : g_bad_chain
         $error("frame_seq: CHAIN_SLOTS must not be negative");
      end
   endgenerate

   fs_state_e state;
   logic      accept, step;

   frame_seq_ctrl u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .op_i        (op_i),
      .mem_ready_i (mem_ready_i),
      .state_o     (state),
      .accept_o    (accept),
      .step_o      (step),
      .done_o      (done_o)
   );

   frame_seq_datapath #(
      .DW          (DW),
      .SLOT_BYTES  (SLOT_BYTES),
      .CHAIN_SLOTS (CHAIN_SLOTS),
      .LEN_LONG    (LEN_LONG),
      .LEN_SHORT   (LEN_SHORT),
      .ALIGN_ADDR  (ALIGN_ADDR)
   ) u_dp (
      .clk         (clk),
      .rst_n       (rst_n),
      .state_i     (state),
      .accept_i    (accept),
      .step_i      (step),
      .op_i        (op_i),
      .pc_i        (pc_i),
      .imm_i       (imm_i),
      .reg_val_i   (reg_val_i),
      .fp_i        (fp_i),
      .sp_i        (sp_i),
      .mem_rdata_i (mem_rdata_i),
      .mem_we_o    (mem_we_o),
      .mem_addr_o  (mem_addr_o),
      .mem_wdata_o (mem_wdata_o),
      .pc_o        (pc_o),
      .fp_o        (fp_o),
      .sp_o        (sp_o)
   );

   assign busy_o    = (state != ST_IDLE);
   assign mem_req_o = (state != ST_IDLE);
endmodule

// File: rtl/frame_seq_chk.sv
module frame_seq_chk #(
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start_i,
   input logic [1:0]    op_i,
   input logic          busy_o,
   input logic          done_o,
   input logic          mem_req_o,
   input logic          mem_we_o,
   input logic [DW-1:0] mem_addr_o,
   input logic [DW-1:0] mem_wdata_o,
   input logic          mem_ready_i,
   input logic [DW-1:0] fp_o,
   input logic [DW-1:0] sp_o
);
   logic [1:0] op_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) op_seen <= 2'd0;
      else if (start_i && !busy_o && (op_i != 2'd3)) op_seen <= op_i;
   end

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)); // R5
   AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |-> busy_o); // R5
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R6
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o); // R6
   AST_STAY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && !mem_ready_i |=> busy_o); // R7
   AST_CALL_LINKS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && (op_seen != 2'd2) |-> fp_o == sp_o); // R2
   AST_UNUSED_OP: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !busy_o && (op_i == 2'd3) |=> !busy_o); // R8
endmodule

bind frame_seq frame_seq_chk #(.DW(DW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .op_i        (op_i),
   .busy_o      (busy_o),
   .done_o      (done_o),
   .mem_req_o   (mem_req_o),
   .mem_we_o    (mem_we_o),
   .mem_addr_o  (mem_addr_o),
   .mem_wdata_o (mem_wdata_o),
   .mem_ready_i (mem_ready_i),
   .fp_o        (fp_o),
   .sp_o        (sp_o)
);

// File: tb/frame_seq_bench.sv
module frame_seq_bench;
   typedef struct {
      logic        we;
      logic [31:0] addr;
      logic [31:0] data;
      string       tag;
   } xfer_t;
   typedef struct {
      logic [31:0] fp;
      logic [31:0] sp;
      logic [31:0] pc;
      string       tag;
   } res_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [1:0]  op_i = 2'd0;
   logic [31:0] pc_i = '0, imm_i = '0, reg_val_i = '0, fp_i = '0, sp_i = '0;
   logic        busy_o, done_o, mem_req_o, mem_we_o;
   logic [31:0] pc_o, fp_o, sp_o, mem_addr_o, mem_wdata_o;
   logic [31:0] mem_rdata_i = '0;
   logic        mem_ready_i = 1'b0;

   int compared = 0;
   int mismatched = 0;
   int mem_delay = 0;
   int wait_cnt = 0;
   int cycles = 0;
   logic prev_done = 1'b0;

   xfer_t exp_x[$];
   res_t  exp_r[$];
   logic [31:0] mem [logic [31:0]];

   always #10 clk = ~clk;

   frame_seq u_frame_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .pc_i(pc_i),
      .imm_i(imm_i), .reg_val_i(reg_val_i), .fp_i(fp_i), .sp_i(sp_i),
      .busy_o(busy_o), .done_o(done_o), .pc_o(pc_o), .fp_o(fp_o), .sp_o(sp_o),
      .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
      .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_ready_i(mem_ready_i)
   );

   function automatic logic [31:0] rd(input logic [31:0] a);
      return mem.exists(a) ? mem[a] : 32'h0;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // memory model and transfer monitor
   always @(negedge clk) begin
      if (mem_ready_i) begin
         mem_ready_i = 1'b0;
         wait_cnt = 0;
      end else if (mem_req_o) begin
         if (wait_cnt < mem_delay) wait_cnt++;
         else begin
            if (exp_x.size() == 0) begin
               compared++; mismatched++;
               $display("FAIL R7: actual unexpected transfer at %h expected none", mem_addr_o);
            end else begin
               xfer_t e;
               e = exp_x.pop_front();
               check({e.tag, " we"}, {31'd0, mem_we_o}, {31'd0, e.we});
               check({e.tag, " addr"}, mem_addr_o, e.addr);
               if (e.we) check({e.tag, " wdata"}, mem_wdata_o, e.data);
            end
            if (mem_we_o) mem[mem_addr_o] = mem_wdata_o;
            else mem_rdata_i = rd(mem_addr_o);
            mem_ready_i = 1'b1;
         end
      end
   end

   // result monitor
   always @(negedge clk) begin
      if (rst_n && done_o) begin
         if (prev_done) check("R6 done width", 32'd1, 32'd0);
         check("R6 busy at done", {31'd0, busy_o}, 32'd0);
         if (exp_r.size() == 0) check("R7 extra done", 32'd1, 32'd0);
         else begin
            res_t r;
            r = exp_r.pop_front();
            check({r.tag, " fp"}, fp_o, r.fp);
            check({r.tag, " sp"}, sp_o, r.sp);
            check({r.tag, " pc"}, pc_o, r.pc);
         end
      end
      prev_done = done_o;
   end

   // driver: pushes expectations, then issues the start
   task automatic run_seq(input logic [1:0] op, input logic [31:0] pc, input logic [31:0] imm,
                          input logic [31:0] rv, input logic [31:0] fp, input logic [31:0] sp,
                          input int dly, input bit poke_busy, input string tag);
      xfer_t x;
      res_t  r;
      mem_delay = dly;
      r.tag = tag;
      if (op == 2'd2) begin
         x.we = 0; x.data = 0; x.tag = tag;
         x.addr = fp;        exp_x.push_back(x);
         x.addr = fp + 4;    exp_x.push_back(x);
         r.fp = rd(fp); r.pc = rd(fp + 4); r.sp = fp + 12;
      end else begin
         x.we = 1; x.tag = tag;
         x.addr = sp - 8;  x.data = pc + ((op == 2'd0) ? 32'd6 : 32'd2); exp_x.push_back(x);
         x.addr = sp - 12; x.data = fp; exp_x.push_back(x);
         r.fp = sp - 12; r.sp = sp - 12; r.pc = (op == 2'd0) ? imm : rv;
      end
      exp_r.push_back(r);
      @(negedge clk);
      start_i = 1; op_i = op; pc_i = pc; imm_i = imm; reg_val_i = rv; fp_i = fp; sp_i = sp;
      @(negedge clk);
      start_i = 0;
      if (poke_busy) begin
         // R7: start during a running sequence with different operands
         check("R7 busy before poke", {31'd0, busy_o}, 32'd1);
         start_i = 1; op_i = 2'd1; pc_i = 32'hDEAD0000; reg_val_i = 32'h0BAD0BAD;
         fp_i = 32'h7770; sp_i = 32'h8880;
         @(negedge clk);
         start_i = 0;
      end
      while (exp_r.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 50000) begin
            compared++; mismatched++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1: reset state
      check("R1 busy", {31'd0, busy_o}, 32'd0);
      check("R1 done", {31'd0, done_o}, 32'd0);
      check("R1 req", {31'd0, mem_req_o}, 32'd0);
      check("R1 pc", pc_o, 32'd0);
      check("R1 fp", fp_o, 32'd0);
      check("R1 sp", sp_o, 32'd0);

      // R2: absolute call, zero wait
      run_seq(2'd0, 32'h100, 32'h4000, 32'h0, 32'h2000, 32'h1000, 0, 0, "R2");
      // R4: return through the frame just built
      run_seq(2'd2, 32'h0, 32'h0, 32'h0, 32'h0FF4, 32'h0, 2, 0, "R4");
      // R3 + R7: register call with a start issued while busy
      run_seq(2'd1, 32'h3330, 32'h0, 32'h9000, 32'h5500, 32'h6000, 1, 1, "R3");
      run_seq(2'd2, 32'h0, 32'h0, 32'h0, 32'h5FF4, 32'h0, 3, 0, "R4 after reg call");
      check("R7 no stray transfers", exp_x.size(), 32'd0);

      // R8: op code 3 is not accepted
      @(negedge clk);
      start_i = 1; op_i = 2'd3; sp_i = 32'h1234;
      @(negedge clk);
      start_i = 0;
      check("R8 busy", {31'd0, busy_o}, 32'd0);
      check("R8 req", {31'd0, mem_req_o}, 32'd0);
      repeat (3) @(negedge clk);
      check("R8 still idle", {31'd0, busy_o}, 32'd0);

      // R9: wraparound below address zero
      run_seq(2'd0, 32'hABC0, 32'h00C0FFEE, 32'h0, 32'h10, 32'h4, 1, 0, "R9 call");
      run_seq(2'd2, 32'h0, 32'h0, 32'h0, 32'hFFFFFFF8, 32'h0, 0, 0, "R9 return");
      check("R9 sp restored", sp_o, 32'h4);
      check("R5 queue drained", exp_x.size(), 32'd0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule